// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits beside the command sequencer of an SDRAM controller and turns one read or write column command into the column address for every beat of the burst. It keeps the programmed CAS latency, wrap order and burst length from the last accepted mode word. A start strobe latches the start column and a snapshot of the burst settings. The block then steps through the beats, one per clock, in sequential or interleaved order. A full-page setting instead walks the whole 512-column row until something stops it.

A burst-stop input ends a burst at once. A new start strobe that arrives during a burst abandons it and begins again from the new column. A restart input replays the most recent burst from its beat zero. Mode words that carry reserved codes are refused and flagged, and the previous settings stay in force.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset, col_valid and col_last are 0, mode_err is 0, cas_lat reports 2, and the burst setting is sequential with length 1.
- R2: A mode write whose bits [6:4] hold 1, 2 or 3, with every other field legal, sets cas_lat to that value and clears mode_err.
- R3: A mode write is refused if any of these holds: bits [6:4] are 0 or 4..7; bits [2:0] are 4, 5 or 6; bits [2:0] are 7 with bit 3 set; any of bits [11:7] is set. A refused write sets mode_err to 1 on the next cycle and leaves CAS latency, wrap order and length unchanged.
- R4: One cycle after a start strobe, col_valid is 1 and col equals the start column latched at that strobe.
- R5: With bit 3 = 0 and bits [2:0] = 0, 1, 2 or 3, the burst has N = 1, 2, 4 or 8 beats. Beat k outputs the start column with its low log2(N) bits replaced by (low bits + k) mod N. The upper bits never change.
- R6: With bit 3 = 1, beat k outputs the start column with its low log2(N) bits XORed with k.
- R7: col_last is 1 exactly on beat N-1 of a finite burst. col_valid falls in the following cycle unless a new start or restart arrives.
- R8: With bits [2:0] = 7 (full page), beat k outputs (start + k) mod 512, wrapping from 511 to 0. col_last stays 0 and the burst runs until it is stopped, restarted or preempted.
- R9: A stop pulse with neither start nor restart drops col_valid in the next cycle.
- R10: A start strobe during a burst abandons it, and the next cycle outputs the new start column. Start takes priority over stop in the same cycle.
- R11: A restart pulse without start replays the most recent burst from beat 0, with the same start column and settings, whether that burst is still running or has ended. Restart takes priority over stop, and start_col is ignored.
- R12: A mode write accepted during a burst does not change that burst's order or length. It takes effect at the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode word write strobe |
| mode_word | input | 12 | Mode word: [6:4] CAS latency, [3] interleave, [2:0] length code |
| start | input | 1 | Begin a burst at start_col |
| restart | input | 1 | Replay the most recent burst from beat 0 |
| stop | input | 1 | End the current burst |
| start_col | input | 9 | Start column for a start strobe |
| cas_lat | output | 2 | Accepted CAS latency (1..3) |
| mode_err | output | 1 | Last mode write was refused |
| col | output | 9 | Column address of the current beat |
| col_valid | output | 1 | A beat is being issued |
| col_last | output | 1 | Current beat is the final beat of a finite burst |

## Verification
The assertions check several rules on every cycle. They check the first beat after a start or restart, the drop of col_valid after a stop or a final beat, and that col_last never appears without col_valid. They also check that the upper column bits hold steady between beats and that a refused mode word changes no setting. They check that the latched burst settings do not move while a burst runs. The directed scenarios are needed for the full address sequences: sequential and interleaved wrap inside the aligned block, the full-page wrap from 511 to 0, and bursts longer than one row. They are also needed for the priority of start over restart over stop, and for showing through a later burst that refused and mid-burst mode writes had the stated effect.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  localparam int CL_W  = 2;
  localparam int LEN_W = 3;

  localparam logic [LEN_W-1:0] LEN_FULL = 3'd7;

  typedef struct packed {
    logic [CL_W-1:0]  cl;
    logic             ilv;
    logic [LEN_W-1:0] len;
  } burst_mode_t;

  localparam burst_mode_t MODE_RESET = '{cl: 2'd2, ilv: 1'b0, len: 3'd0};

  function automatic logic cl_code_ok(input logic [2:0] code);
    return (code == 3'd1) || (code == 3'd2) || (code == 3'd3);
  endfunction

  function automatic logic len_code_ok(input logic [LEN_W-1:0] code, input logic ilv);
    logic ok;
    case (code)
      3'd0, 3'd1, 3'd2, 3'd3: ok = 1'b1;
      LEN_FULL:               ok = ~ilv;
      default:                ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/colgen_mode_reg.sv
module colgen_mode_reg
  import colgen_pkg::*;
#(
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [MODE_W-1:0] word,
  output burst_mode_t       mode,
  output logic              err
);

  localparam int RSV_LO = 7;

  burst_mode_t mode_q, mode_d;
  logic        err_q, err_d;
  logic        word_ok;

  always_comb begin
    word_ok = (word[MODE_W-1:RSV_LO] == '0)
            && cl_code_ok(word[6:4])
            && len_code_ok(word[2:0], word[3]);
  end

  always_comb begin
    mode_d = mode_q;
    err_d  = err_q;
    if (wr) begin
      if (word_ok) begin
        mode_d.cl  = word[5:4];
        mode_d.ilv = word[3];
        mode_d.len = word[2:0];
        err_d      = 1'b0;
      end else begin
        err_d      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET;
      err_q  <= 1'b0;
    end else if (wr) begin
      mode_q <= mode_d;
      err_q  <= err_d;
    end
  end

  assign mode = mode_q;
  assign err  = err_q;

  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !word_ok) |=> ($stable(mode_q) && err_q)); // R3

  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(mode_q)); // R3

  AST_CL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.cl != 2'd0); // R2

endmodule

// File: rtl/colgen_burst_ctl.sv
module colgen_burst_ctl
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             restart,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_ilv,
  output logic             active,
  output logic             last,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] mask,
  output logic             ilv
);

  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic             act_q, act_d;
  logic [COL_W-1:0] beat_q, beat_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             ilv_q, ilv_d;
  logic             full;
  logic             at_end;

  always_comb begin
    full = (len_q == LEN_FULL);
    mask = full ? '1 : ((ONE << len_q[1:0]) - ONE);
    at_end = act_q && !full && (beat_q == mask);
  end

  always_comb begin
    act_d  = act_q;
    beat_d = beat_q;
    base_d = base_q;
    len_d  = len_q;
    ilv_d  = ilv_q;
    if (start) begin
      act_d  = 1'b1;
      beat_d = '0;
      base_d = start_col;
      len_d  = cfg_len;
      ilv_d  = cfg_ilv;
    end else if (restart) begin
      act_d  = 1'b1;
      beat_d = '0;
    end else if (stop) begin
      act_d  = 1'b0;
    end else if (act_q) begin
      if (at_end) begin
        act_d  = 1'b0;
      end else begin
        beat_d = beat_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      beat_q <= '0;
      base_q <= '0;
      len_q  <= MODE_RESET.len;
      ilv_q  <= MODE_RESET.ilv;
    end else begin
      act_q  <= act_d;
      beat_q <= beat_d;
      if (start) begin
        base_q <= base_d;
        len_q  <= len_d;
        ilv_q  <= ilv_d;
      end
    end
  end

  assign active = act_q;
  assign last   = at_end;
  assign beat   = beat_q;
  assign base   = base_q;
  assign ilv    = ilv_q;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(len_q) && $stable(ilv_q) && $stable(base_q))); // R12

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !start) |=> (act_q && beat_q == '0)); // R11

endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] ilv_col;

  assign seq_col = base + beat;
  assign ilv_col = base ^ beat;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col[i] = mask[i] ? (ilv ? ilv_col[i] : seq_col[i]) : base[i];
  end

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
  import colgen_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              start,
  input  logic              restart,
  input  logic              stop,
  input  logic [COL_W-1:0]  start_col,
  output logic [CL_W-1:0]   cas_lat,
  output logic              mode_err,
  output logic [COL_W-1:0]  col,
  output logic              col_valid,
  output logic              col_last
);

  burst_mode_t      mode;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] base;
  logic [COL_W-1:0] mask;
  logic             ilv;

  colgen_mode_reg #(.MODE_W(MODE_W)) i_mode (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (mode_wr),
    .word (mode_word),
    .mode (mode),
    .err  (mode_err)
  );

  colgen_burst_ctl #(.COL_W(COL_W)) i_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .restart  (restart),
    .stop     (stop),
    .start_col(start_col),
    .cfg_len  (mode.len),
    .cfg_ilv  (mode.ilv),
    .active   (col_valid),
    .last     (col_last),
    .beat     (beat),
    .base     (base),
    .mask     (mask),
    .ilv      (ilv)
  );

  colgen_addr_map #(.COL_W(COL_W)) i_map (
    .base(base),
    .beat(beat),
    .mask(mask),
    .ilv (ilv),
    .col (col)
  );

  assign cas_lat = mode.cl;

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_valid && col == $past(start_col))); // R4

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start && !restart) |=> !col_valid); // R9

  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid); // R7

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last && !start && !restart) |=> !col_valid); // R7

  AST_RESTART_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !start) |=> (col_valid && col == base)); // R11

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !start && !restart) |=> (!col_valid || ((col ^ $past(col)) & ~mask) == '0)); // R5

endmodule

// File: tb/test_sdram_col_seq.sv
module test_sdram_col_seq;

  localparam int CLK_PERIOD = 10;
  localparam int COL_W      = 9;
  localparam int MODE_W     = 12;

  logic              clk;
  logic              rst_n;
  logic              mode_wr;
  logic [MODE_W-1:0] mode_word;
  logic              start;
  logic              restart;
  logic              stop;
  logic [COL_W-1:0]  start_col;
  logic [1:0]        cas_lat;
  logic              mode_err;
  logic [COL_W-1:0]  col;
  logic              col_valid;
  logic              col_last;

  int n_chk  = 0;
  int n_fail = 0;

  sdram_col_seq #(.COL_W(COL_W), .MODE_W(MODE_W)) i_sdram_col_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_wr  (mode_wr),
    .mode_word(mode_word),
    .start    (start),
    .restart  (restart),
    .stop     (stop),
    .start_col(start_col),
    .cas_lat  (cas_lat),
    .mode_err (mode_err),
    .col      (col),
    .col_valid(col_valid),
    .col_last (col_last)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int exp_col(input int b, input int k, input int lc, input bit il);
    int n, lo, hi;
    if (lc == 7) return (b + k) % 512;
    n  = 1 << lc;
    lo = b % n;
    hi = b - lo;
    return il ? hi + (lo ^ k) : hi + ((lo + k) % n);
  endfunction

  function automatic logic [MODE_W-1:0] mw(input int cl, input bit bt, input int bl);
    logic [2:0] c3, b3;
    c3 = cl[2:0];
    b3 = bl[2:0];
    return {5'b0, c3, bt, b3};
  endfunction

  task automatic wr_mode(input logic [MODE_W-1:0] w);
    mode_wr   = 1'b1;
    mode_word = w;
    tick();
    mode_wr   = 1'b0;
  endtask

  task automatic launch(input int c);
    start_col = c[COL_W-1:0];
    start     = 1'b1;
    tick();
    start     = 1'b0;
  endtask

  task automatic run_burst(input string req, input int b, input int lc, input bit il);
    int n;
    n = 1 << lc;
    launch(b);
    for (int k = 0; k < n; k++) begin
      check({req, " valid"}, col_valid, 1);
      check({req, " col"}, col, exp_col(b, k, lc, il));
      check({req, " last"}, col_last, (k == n - 1) ? 1 : 0);
      tick();
    end
    check({req, " R7 end"}, col_valid, 0);
  endtask

  task automatic t_reset();
    check("R1 valid", col_valid, 0);
    check("R1 last", col_last, 0);
    check("R1 err", mode_err, 0);
    check("R1 cl", cas_lat, 2);
    run_burst("R1 default len1", 57, 0, 0);
  endtask

  task automatic t_cas();
    wr_mode(mw(1, 0, 2));
    check("R2 cl1", cas_lat, 1);
    wr_mode(mw(2, 0, 2));
    check("R2 cl2", cas_lat, 2);
    wr_mode(mw(3, 0, 2));
    check("R2 cl3", cas_lat, 3);
    check("R2 err", mode_err, 0);
  endtask

  task automatic t_seq();
    run_burst("R5 seq4", 214, 2, 0);
    wr_mode(mw(3, 0, 3));
    run_burst("R5 seq8", 507, 3, 0);
    wr_mode(mw(3, 0, 1));
    run_burst("R5 seq2", 77, 1, 0);
    run_burst("R4 seq2 aligned", 0, 1, 0);
  endtask

  task automatic t_ilv();
    wr_mode(mw(3, 1, 3));
    run_burst("R6 ilv8", 349, 3, 1);
    wr_mode(mw(3, 1, 2));
    run_burst("R6 ilv4", 6, 2, 1);
  endtask

  task automatic t_short();
    wr_mode(mw(3, 0, 0));
    run_burst("R7 len1", 100, 0, 0);
  endtask

  task automatic t_reserved();
    wr_mode(mw(0, 0, 2));
    check("R3 cl0 err", mode_err, 1);
    check("R3 cl0 keep", cas_lat, 3);
    wr_mode(mw(5, 0, 2));
    check("R3 cl5 err", mode_err, 1);
    wr_mode(mw(1, 0, 5));
    check("R3 len5 err", mode_err, 1);
    check("R3 len5 keep cl", cas_lat, 3);
    wr_mode(mw(1, 1, 7));
    check("R3 ilv full err", mode_err, 1);
    wr_mode(mw(1, 0, 2) | 12'h200);
    check("R3 high bit err", mode_err, 1);
    check("R3 high bit keep", cas_lat, 3);
    run_burst("R3 len kept", 300, 0, 0);
    wr_mode(mw(2, 0, 2));
    check("R3 err cleared", mode_err, 0);
    check("R3 new cl", cas_lat, 2);
  endtask

  task automatic t_full();
    wr_mode(mw(2, 0, 7));
    launch(509);
    for (int k = 0; k < 6; k++) begin
      check("R8 wrap col", col, exp_col(509, k, 7, 0));
      check("R8 no last", col_last, 0);
      if (k < 5) tick();
    end
    stop = 1'b1;
    tick();
    stop = 1'b0;
    check("R9 stop", col_valid, 0);
    launch(3);
    for (int k = 0; k < 520; k++) begin
      check("R8 long", col, exp_col(3, k, 7, 0));
      check("R8 long valid", col_valid, 1);
      check("R8 long no last", col_last, 0);
      tick();
    end
    stop = 1'b1;
    tick();
    stop = 1'b0;
    check("R9 stop full", col_valid, 0);
  endtask

  task automatic t_preempt();
    wr_mode(mw(2, 0, 3));
    launch(16);
    check("R10 first", col, 16);
    tick();
    check("R10 second", col, 17);
    start_col = 9'd40;
    start     = 1'b1;
    stop      = 1'b1;
    tick();
    start     = 1'b0;
    stop      = 1'b0;
    check("R10 new col", col, 40);
    check("R10 valid", col_valid, 1);
    for (int k = 1; k < 8; k++) begin
      tick();
      check("R10 run", col, 40 + k);
      check("R10 last", col_last, (k == 7) ? 1 : 0);
    end
    tick();
    check("R10 end", col_valid, 0);
  endtask

  task automatic t_restart();
    wr_mode(mw(2, 0, 2));
    launch(33);
    check("R11 first", col, 33);
    tick();
    check("R11 second", col, 34);
    start_col = 9'd99;
    restart   = 1'b1;
    stop      = 1'b1;
    tick();
    restart   = 1'b0;
    stop      = 1'b0;
    check("R11 replay", col, 33);
    check("R11 valid", col_valid, 1);
    for (int k = 1; k < 4; k++) begin
      tick();
      check("R11 run", col, exp_col(33, k, 2, 0));
      check("R11 last", col_last, (k == 3) ? 1 : 0);
    end
    tick();
    check("R11 end", col_valid, 0);
    restart = 1'b1;
    tick();
    restart = 1'b0;
    check("R11 after end", col, 33);
    check("R11 after end valid", col_valid, 1);
    repeat (4) tick();
    check("R11 after end done", col_valid, 0);
  endtask

  task automatic t_mode_mid();
    launch(8);
    check("R12 first", col, 8);
    wr_mode(mw(2, 1, 3));
    check("R12 order kept", col, 9);
    tick();
    check("R12 third", col, 10);
    tick();
    check("R12 len kept", col_last, 1);
    check("R12 fourth", col, 11);
    tick();
    check("R12 end", col_valid, 0);
    run_burst("R12 next uses new", 13, 3, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    mode_wr   = 1'b0;
    mode_word = '0;
    start     = 1'b0;
    restart   = 1'b0;
    stop      = 1'b0;
    start_col = '0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_cas();
    t_seq();
    t_ilv();
    t_short();
    t_reserved();
    t_full();
    t_preempt();
    t_restart();
    t_mode_mid();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule